// File: doc/BRIEF.md
# Message Schedule Finishing Stage

This block produces four new 32-bit words of a hash message schedule (positions 16 to 19) in one operation. It takes three 128-bit operands. The first holds four partial sums from an earlier scheduling stage. The second holds schedule words 3 to 6. The third holds words 10 to 13. Each operand carries its words as dwords 0 to 3, with dword k in bits 32k+31 down to 32k. The result is one 128-bit word group, with word 16 in dword 0 and word 19 in dword 3.

Each output lane combines its three input words. The lane takes the word from the second operand rotated left by 7, then XORs in the third-operand word and the partial sum. The fourth lane then gets one more correction. That correction is built from word 16 of the same operation, so the dependency between lanes of one group is resolved inside the block by a combinational chain. The result is registered. A request raised on `in_valid` appears on `out_valid` and `word_o` exactly one clock later. Operations may be issued on consecutive cycles.

Top module: `msgx2_stage`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, `out_valid` is 0 and `word_o` is all zeros after that edge.
- R2: `out_valid` after a rising edge equals `in_valid` sampled at that edge, so the latency is exactly one clock.
- R3: For lanes k = 0, 1 and 2, dword k of the result is rotl(early dword k, 7) XOR mid dword k XOR partial dword k. Here rotl moves bits toward the MSB and bit 31 wraps into bit 0.
- R4: Dword 3 of the result starts from the same lane formula as R3. It is then XORed with rotl(w16, 6), rotl(w16, 15) and rotl(w16, 30), where w16 is dword 0 of that same result.
- R5: When `in_valid` is sampled low, `word_o` keeps its previous value whatever the operand inputs carry.
- R6: In operations issued on back-to-back cycles, the dword 3 correction of each result uses only the word 16 of its own operation and never that of the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| partial_i | input | 128 | Partial sums from the earlier stage, lanes 0..3 |
| early_i | input | 128 | Schedule words 3..6 |
| mid_i | input | 128 | Schedule words 10..13 |
| out_valid | output | 1 | Result valid |
| word_o | output | 128 | Finished words 16..19 |

## Verification
The only state in the block is the result register and its valid flag, so any wrong capture shows at the ports one clock after the request. A wrong capture here means a missed load, a load taken while idle, or a stale value. A fault in the lane datapath changes the matching dword at once. A fault in the correction chain leaves dwords 0 to 2 intact and corrupts only dword 3. Back-to-back requests with different operands expose a correction that reads a registered word 16 instead of the current one, and the error appears on the second result of the pair.

// File: rtl/msgx2_pkg.sv
// Package: shared widths, rotation amounts and the rotate helper for the
// message schedule finishing stage. Assumes 32-bit words, four lanes.
package msgx2_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned LANES     = 4;
    localparam int unsigned BUS_W     = WORD_W * LANES;
    localparam int unsigned LAST_LANE = LANES - 1;

    // Rotation applied to the older-word operand in every lane.
    localparam int unsigned ROT_EARLY = 7;
    // Rotations of word 16 folded into the last lane.
    localparam int unsigned ROT_FIX_0 = 6;
    localparam int unsigned ROT_FIX_1 = 15;
    localparam int unsigned ROT_FIX_2 = 30;

    typedef logic [WORD_W-1:0] word_t;

    // Left rotate toward the MSB; n must lie in 1..WORD_W-1.
    function automatic word_t rotl(input word_t x, input int unsigned n);
        word_t r;
        r = (x << n) | (x >> (WORD_W - n));
        return r;
    endfunction
endpackage

// File: rtl/msgx2_lane.sv
// Lane mixer: combines one older word (rotated), one middle word and one
// partial sum into the uncorrected new word. Purely combinational.
module msgx2_lane
    import msgx2_pkg::*;
(
    input  word_t partial_i,
    input  word_t early_i,
    input  word_t mid_i,
    output word_t mix_o
);
    // Three-input XOR of the lane operands.
    assign mix_o = rotl(early_i, ROT_EARLY) ^ mid_i ^ partial_i;
endmodule

// File: rtl/msgx2_fold.sv
// Cross-lane fold: corrects the last lane with three rotations of the first
// lane's word from the same operation. Assumes head_i is combinational from
// the current operands, never a registered value.
module msgx2_fold
    import msgx2_pkg::*;
(
    input  word_t head_i,
    input  word_t tail_i,
    output word_t tail_o
);
    word_t spread;

    // Spread the head word over three rotations.
    assign spread = rotl(head_i, ROT_FIX_0) ^ rotl(head_i, ROT_FIX_1) ^ rotl(head_i, ROT_FIX_2);
    // Apply the correction to the last lane.
    assign tail_o = tail_i ^ spread;
endmodule

// File: rtl/msgx2_outreg.sv
// Result register with valid flag. Loads data only on load_i, holds it
// otherwise; synchronous active-low reset clears both flag and data.
module msgx2_outreg #(
    parameter int unsigned W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic         valid_o,
    output logic [W-1:0] q_o
);
    // Valid flag follows the request with one clock of delay.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= load_i;
    end

    // Data captured on request, held while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= '0;
        else if (load_i) q_o <= d_i;
    end
endmodule

// File: rtl/msgx2_stage.sv
// Top: message schedule finishing stage. Splits the three operand buses
// into lanes, mixes each lane, folds lane 0 into the last lane within the
// same cycle, and registers the packed result. Latency one clock.
module msgx2_stage
    import msgx2_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [BUS_W-1:0] partial_i,
    input  logic [BUS_W-1:0] early_i,
    input  logic [BUS_W-1:0] mid_i,
    output logic             out_valid,
    output logic [BUS_W-1:0] word_o
);
    word_t            mix [LANES];
    word_t            tail_fixed;
    logic [BUS_W-1:0] result;

    // One mixer per lane, operands sliced by lane index.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        msgx2_lane lane_i (
            .partial_i (partial_i[k*WORD_W +: WORD_W]),
            .early_i   (early_i[k*WORD_W +: WORD_W]),
            .mid_i     (mid_i[k*WORD_W +: WORD_W]),
            .mix_o     (mix[k])
        );
    end

    // Same-cycle dependency: last lane corrected from lane 0.
    msgx2_fold fold_i (
        .head_i (mix[0]),
        .tail_i (mix[LAST_LANE]),
        .tail_o (tail_fixed)
    );

    // Pack lanes: all but the last pass through, the last is corrected.
    for (genvar k = 0; k < LANES; k++) begin : g_pack
        if (k == LAST_LANE) begin : g_tail
            assign result[k*WORD_W +: WORD_W] = tail_fixed;
        end else begin : g_body
            assign result[k*WORD_W +: WORD_W] = mix[k];
        end
    end

    msgx2_outreg #(.W(BUS_W)) oreg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (in_valid),
        .d_i     (result),
        .valid_o (out_valid),
        .q_o     (word_o)
    );
endmodule

// File: rtl/msgx2_stage_chk.sv
// Checker for msgx2_stage: port-level timing and data properties.
module msgx2_stage_chk
    import msgx2_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [BUS_W-1:0] partial_i,
    input logic [BUS_W-1:0] early_i,
    input logic [BUS_W-1:0] mid_i,
    input logic             out_valid,
    input logic [BUS_W-1:0] word_o
);
    logic armed = 1'b0;
    logic rst_d;

    // Track the reset level seen at the previous edge.
    always_ff @(posedge clk) begin
        armed <= 1'b1;
        rst_d <= rst_n;
    end

    // R1
    always_ff @(posedge clk) begin
        if (armed && !rst_d) begin
            reset_clears_chk: assert (!out_valid && word_o == '0)
                else $error("reset did not clear the result register");
        end
    end

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    lane0_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> word_o[WORD_W-1:0] ==
            (rotl($past(early_i[WORD_W-1:0]), ROT_EARLY) ^ $past(mid_i[WORD_W-1:0])
             ^ $past(partial_i[WORD_W-1:0])));

    // R4
    tail_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> word_o[BUS_W-1 -: WORD_W] ==
            (rotl($past(early_i[BUS_W-1 -: WORD_W]), ROT_EARLY) ^ $past(mid_i[BUS_W-1 -: WORD_W])
             ^ $past(partial_i[BUS_W-1 -: WORD_W])
             ^ rotl(word_o[WORD_W-1:0], ROT_FIX_0) ^ rotl(word_o[WORD_W-1:0], ROT_FIX_1)
             ^ rotl(word_o[WORD_W-1:0], ROT_FIX_2)));

    // R5
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(word_o));
endmodule

bind msgx2_stage msgx2_stage_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .partial_i (partial_i),
    .early_i   (early_i),
    .mid_i     (mid_i),
    .out_valid (out_valid),
    .word_o    (word_o)
);

// File: tb/msgx2_stage_tb.sv
// Bench: directed corners plus seeded random operations, checked against
// expected words computed by bench functions.
module msgx2_stage_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] partial_i = '0;
    logic [127:0] early_i = '0;
    logic [127:0] mid_i = '0;
    logic         out_valid;
    logic [127:0] word_o;

    int checks = 0;
    int fails  = 0;
    logic [127:0] last_word = '0;

    always #10 clk = ~clk;   // 50 MHz

    msgx2_stage dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .partial_i (partial_i),
        .early_i   (early_i),
        .mid_i     (mid_i),
        .out_valid (out_valid),
        .word_o    (word_o)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input logic [127:0] c);
        logic [31:0] w [4];
        for (int k = 0; k < 4; k++)
            w[k] = rl(b[32*k +: 32], 7) ^ c[32*k +: 32] ^ a[32*k +: 32];
        w[3] = w[3] ^ rl(w[0], 6) ^ rl(w[0], 15) ^ rl(w[0], 30);
        return {w[3], w[2], w[1], w[0]};
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // One request, checked at the next falling edge; tag names the dword 3 rule.
    task automatic issue(input logic [127:0] a, input logic [127:0] b, input logic [127:0] c,
                         input string tail_tag);
        logic [127:0] e;
        e = model(a, b, c);
        partial_i = a; early_i = b; mid_i = c; in_valid = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b1, "R2 valid", {127'd0, out_valid}, 128'd1);
        for (int k = 0; k < 3; k++)
            check(word_o[32*k +: 32] == e[32*k +: 32], "R3 lane", word_o, e);
        check(word_o[127:96] == e[127:96], tail_tag, word_o, e);
        last_word = e;
    endtask

    // Idle cycles with garbage operands; output must hold.
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0;
            partial_i = rnd128(); early_i = rnd128(); mid_i = rnd128();
            @(negedge clk);
            check(out_valid == 1'b0, "R2 idle", {127'd0, out_valid}, 128'd0);
            check(word_o == last_word, "R5 hold", word_o, last_word);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        in_valid = 1'b1;   // request during reset must be dropped
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid", {127'd0, out_valid}, 128'd0);
        check(word_o == '0, "R1 data", word_o, '0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);

        // Directed corners.
        issue('0, '0, '0, "R4 zero");
        issue('1, '1, '1, "R4 ones");
        issue('0, {4{32'h8000_0000}}, '0, "R4 wrap");
        issue({96'd0, 32'h0000_0001}, '0, '0, "R4 head only");
        issue('0, '0, {32'hDEAD_BEEF, 96'd0}, "R4 tail only");
        idle(3);

        // Back-to-back with differing lane 0 words.
        for (int i = 0; i < 20; i++)
            issue(rnd128(), rnd128(), rnd128(), "R6 back-to-back");
        idle(2);

        // Random requests with random gaps.
        for (int i = 0; i < 300; i++) begin
            issue(rnd128(), rnd128(), rnd128(), "R4 random");
            if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
        end

        // Reset in mid-stream with a request pending.
        partial_i = rnd128(); early_i = rnd128(); mid_i = rnd128();
        in_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 mid valid", {127'd0, out_valid}, 128'd0);
        check(word_o == '0, "R1 mid data", word_o, '0);
        rst_n = 1'b1; in_valid = 1'b0; last_word = '0;
        @(negedge clk);
        idle(1);
        issue(rnd128(), rnd128(), rnd128(), "R4 after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule